// File: doc/BRIEF.md
# Dual-Set Pattern Bank Address Generator

The block turns a 13-bit pattern-space address from a video fetcher into a physical pattern-ROM address. It keeps twelve bank registers in two sets. Set A has eight entries and set B has four. A 2-bit page-size register splits the pattern space into one, two, four or eight pages. Every value written to a bank register gets two upper bits from a separate upper-bits register.

The block picks a register set for each fetch. Normally it uses the set that software wrote last. When tall (8x16) sprites are on, the fetch phase decides instead: sprite fetches use set A and background fetches use set B.

An extended-attribute mode adds a per-tile override. Each background nametable fetch latches a 4 KB bank taken from the byte read from internal RAM. The background pattern fetches that follow then use the latched bank. Writing the page-size register, any bank register or the upper-bits register cancels this override. The address output is combinational. The pattern ROM sits outside the block.

Top module: `pat_bank_addr_gen`

## Requirements
- R1: After reset the page mode is 3, every bank register holds all ones (0x3FF), set A is the last-written set, the upper bits are 0 and no override is active. With these values the output is {0x3FF, pat_addr[9:0]}.
- R2: A write to 0x5120+i (i = 0..11) stores {upper[1:0], wr_data[7:0]} in register i. Registers 0..7 form set A and registers 8..11 form set B. A write to any set A register marks set A as last written, and a write to any set B register marks set B. The upper bits are written at 0x5130 from wr_data[1:0].
- R3: In page mode 3 (1 KB pages), the output is {reg, pat_addr[9:0]}. The register index is pat_addr[12:10] for set A and 8+pat_addr[11:10] for set B.
- R4: In page mode 2 (2 KB pages), the output is {reg, pat_addr[10:0]}. The set A index is {pat_addr[12:11],1}. The set B index is 9 when pat_addr[11] is 0 and 11 when it is 1.
- R5: In page mode 1 (4 KB pages), the output is {reg[7:0], pat_addr[11:0]}. Set A uses register 3 when pat_addr[12] is 0 and register 7 when it is 1. Set B uses register 11.
- R6: In page mode 0, set A gives {reg7[7:0], pat_addr[12:0]}, one 8 KB page. Set B gives {reg11[7:0], pat_addr[11:0]}, a 4 KB-granular page.
- R7: When set B is in use, pat_addr[12] has no effect on the output, so set B repeats across both 4 KB halves of the pattern space.
- R8: With tall_spr high, a fetch with fetch_bg low uses set A and a fetch with fetch_bg high uses set B, whichever set was written last. With tall_spr low, every fetch uses the last-written set.
- R9: While ext_attr_en is high, a cycle with nt_fetch high latches the bank {upper[1:0], nt_byte[5:0]}, and the override becomes active on the next cycle. While the override is active, ext_attr_en is high and fetch_bg is high, the output is {bank, pat_addr[11:0]}. Sprite fetches, and any fetch with ext_attr_en low, use the normal mapping. A cycle with nt_fetch high and ext_attr_en low latches nothing.
- R10: A write to the page-mode register (0x5101, wr_data[1:0]), to any bank register or to 0x5130 cancels the override from the next cycle. This write wins over an nt_fetch in the same cycle. Writes to any other address leave the override in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Register write address |
| wr_data | input | 8 | Register write data |
| ext_attr_en | input | 1 | Extended-attribute (per-tile bank) mode enabled |
| nt_fetch | input | 1 | Background nametable tile fetch this cycle |
| nt_byte | input | 8 | Internal-RAM byte read with that nametable fetch |
| pat_addr | input | 13 | Pattern-space fetch address |
| fetch_bg | input | 1 | 1 = background-phase fetch, 0 = sprite-phase fetch |
| tall_spr | input | 1 | 8x16 sprites enabled |
| rom_addr | output | 21 | Physical pattern-ROM address (combinational) |

## Verification
The assertions assume two things about the inputs. First, the fetch inputs (pat_addr, fetch_bg, tall_spr, ext_attr_en) are stable at each rising edge. Second, write and nametable-fetch strobes last exactly one cycle. The bench meets both by changing every input only on the falling edge and pulsing each strobe for a single cycle. The mapping checks look only at the combinational output, sampled after the inputs settle. The override checks are made one full cycle after the strobe that latches or cancels the override.

// File: rtl/patbank_pkg.sv
package patbank_pkg;
    typedef enum logic [1:0] {
        PG_8K = 2'd0,
        PG_4K = 2'd1,
        PG_2K = 2'd2,
        PG_1K = 2'd3
    } page_mode_e;
endpackage

// File: rtl/pb_regfile.sv
module pb_regfile
    import patbank_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int HI_W      = 2,
    parameter int ADDR_W    = 16,
    parameter int BANKS_A   = 8,
    parameter int BANKS_B   = 4,
    parameter int MODE_ADR  = 'h5101,
    parameter int BANK_ADR  = 'h5120,
    parameter int UPPER_ADR = 'h5130,
    localparam int BANK_W   = DATA_W + HI_W,
    localparam int NREG     = BANKS_A + BANKS_B
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [NREG-1:0][BANK_W-1:0]   banks,
    output page_mode_e                    mode,
    output logic                          last_b,
    output logic [HI_W-1:0]               upper,
    output logic                          cancel
);
    typedef struct packed {
        logic [NREG-1:0][BANK_W-1:0] bank;
        page_mode_e                  mode;
        logic                        last_b;
        logic [HI_W-1:0]             upper;
    } rf_state_t;

    rf_state_t st_d, st_q;
    logic      hit_any;

    always_comb begin
        st_d    = st_q;
        hit_any = 1'b0;
        if (wr_en) begin
            for (int i = 0; i < NREG; i++) begin
                if (wr_addr == ADDR_W'(BANK_ADR + i)) begin
                    st_d.bank[i] = {st_q.upper, wr_data};
                    st_d.last_b  = (i >= BANKS_A);
                    hit_any      = 1'b1;
                end
            end
            if (wr_addr == ADDR_W'(MODE_ADR)) begin
                st_d.mode = page_mode_e'(wr_data[1:0]);
                hit_any   = 1'b1;
            end
            if (wr_addr == ADDR_W'(UPPER_ADR)) begin
                st_d.upper = wr_data[HI_W-1:0];
                hit_any    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.bank   <= '1;
            st_q.mode   <= PG_1K;
            st_q.last_b <= 1'b0;
            st_q.upper  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign banks  = st_q.bank;
    assign mode   = st_q.mode;
    assign last_b = st_q.last_b;
    assign upper  = st_q.upper;
    assign cancel = hit_any;

    // R2
    last_set_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= ADDR_W'(BANK_ADR + BANKS_A) && wr_addr < ADDR_W'(BANK_ADR + NREG))
        |=> last_b);

    // R2
    last_set_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= ADDR_W'(BANK_ADR) && wr_addr < ADDR_W'(BANK_ADR + BANKS_A))
        |=> !last_b);
endmodule

// File: rtl/pb_ext_latch.sv
module pb_ext_latch #(
    parameter int DATA_W = 8,
    parameter int HI_W   = 2,
    parameter int LO_W   = 6,
    localparam int OVR_W = HI_W + LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_attr_en,
    input  logic              nt_fetch,
    input  logic [DATA_W-1:0] nt_byte,
    input  logic [HI_W-1:0]   upper,
    input  logic              cancel,
    output logic              ovr_valid,
    output logic [OVR_W-1:0]  ovr_bank
);
    typedef struct packed {
        logic             valid;
        logic [OVR_W-1:0] bank;
    } ovr_state_t;

    ovr_state_t ov_d, ov_q;

    always_comb begin
        ov_d = ov_q;
        if (cancel) begin
            ov_d.valid = 1'b0;
        end else if (nt_fetch && ext_attr_en) begin
            ov_d.valid = 1'b1;
            ov_d.bank  = {upper, nt_byte[LO_W-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_q <= '0;
        end else begin
            ov_q <= ov_d;
        end
    end

    assign ovr_valid = ov_q.valid;
    assign ovr_bank  = ov_q.bank;

    // R10
    ovr_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> !ovr_valid);

    // R9
    ovr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nt_fetch && ext_attr_en && !cancel) |=> (ovr_valid && ovr_bank[LO_W-1:0] == $past(nt_byte[LO_W-1:0])));

    // R9
    ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nt_fetch && !cancel) |=> $stable(ovr_valid));
endmodule

// File: rtl/pb_addr_mux.sv
module pb_addr_mux
    import patbank_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int HI_W     = 2,
    parameter int BANKS_A  = 8,
    parameter int BANKS_B  = 4,
    parameter int OVR_W    = 8,
    localparam int BANK_W  = DATA_W + HI_W,
    localparam int NREG    = BANKS_A + BANKS_B,
    localparam int IDX_W   = $clog2(NREG),
    localparam int ROM_AW  = (HI_W >= 2) ? BANK_W + 11 : DATA_W + 13
) (
    input  logic [NREG-1:0][BANK_W-1:0] banks,
    input  page_mode_e                  mode,
    input  logic                        last_b,
    input  logic                        tall_spr,
    input  logic                        fetch_bg,
    input  logic                        ext_attr_en,
    input  logic                        ovr_valid,
    input  logic [OVR_W-1:0]            ovr_bank,
    input  logic [12:0]                 pat_addr,
    output logic [ROM_AW-1:0]           rom_addr
);
    localparam logic [IDX_W-1:0] B0 = IDX_W'(BANKS_A);

    logic             use_b;
    logic [IDX_W-1:0] idx;
    logic [BANK_W-1:0] sel;

    always_comb begin
        use_b    = tall_spr ? fetch_bg : last_b;
        idx      = '0;
        rom_addr = '0;
        unique case (mode)
            PG_1K: idx = use_b ? (B0 + IDX_W'(pat_addr[11:10]))
                               : IDX_W'(pat_addr[12:10]);
            PG_2K: idx = use_b ? (B0 + IDX_W'({pat_addr[11], 1'b1}))
                               : IDX_W'({pat_addr[12:11], 1'b1});
            PG_4K: idx = use_b ? (B0 + IDX_W'(3))
                               : IDX_W'({pat_addr[12], 2'b11});
            default: idx = use_b ? (B0 + IDX_W'(3)) : IDX_W'(7);
        endcase
        sel = banks[idx];

        unique case (mode)
            PG_1K: rom_addr = (ROM_AW'(sel) << 10) | ROM_AW'(pat_addr[9:0]);
            PG_2K: rom_addr = (ROM_AW'(sel) << 11) | ROM_AW'(pat_addr[10:0]);
            PG_4K: rom_addr = (ROM_AW'(sel[DATA_W-1:0]) << 12) | ROM_AW'(pat_addr[11:0]);
            default: begin
                if (use_b)
                    rom_addr = (ROM_AW'(sel[DATA_W-1:0]) << 12) | ROM_AW'(pat_addr[11:0]);
                else
                    rom_addr = (ROM_AW'(sel[DATA_W-1:0]) << 13) | ROM_AW'(pat_addr[12:0]);
            end
        endcase

        if (ext_attr_en && fetch_bg && ovr_valid)
            rom_addr = (ROM_AW'(ovr_bank) << 12) | ROM_AW'(pat_addr[11:0]);
    end
endmodule

// File: rtl/pat_bank_addr_gen.sv
module pat_bank_addr_gen
    import patbank_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int HI_W      = 2,
    parameter int ADDR_W    = 16,
    parameter int BANKS_A   = 8,
    parameter int BANKS_B   = 4,
    parameter int LO_W      = 6,
    parameter int MODE_ADR  = 'h5101,
    parameter int BANK_ADR  = 'h5120,
    parameter int UPPER_ADR = 'h5130,
    localparam int BANK_W   = DATA_W + HI_W,
    localparam int NREG     = BANKS_A + BANKS_B,
    localparam int OVR_W    = HI_W + LO_W,
    localparam int ROM_AW   = (HI_W >= 2) ? BANK_W + 11 : DATA_W + 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ext_attr_en,
    input  logic              nt_fetch,
    input  logic [DATA_W-1:0] nt_byte,
    input  logic [12:0]       pat_addr,
    input  logic              fetch_bg,
    input  logic              tall_spr,
    output logic [ROM_AW-1:0] rom_addr
);
    logic [NREG-1:0][BANK_W-1:0] banks_w;
    page_mode_e                  mode_w;
    logic                        last_b_w;
    logic [HI_W-1:0]             upper_w;
    logic                        cancel_w;
    logic                        ovr_valid_w;
    logic [OVR_W-1:0]            ovr_bank_w;

    pb_regfile #(
        .DATA_W(DATA_W), .HI_W(HI_W), .ADDR_W(ADDR_W),
        .BANKS_A(BANKS_A), .BANKS_B(BANKS_B),
        .MODE_ADR(MODE_ADR), .BANK_ADR(BANK_ADR), .UPPER_ADR(UPPER_ADR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .banks(banks_w), .mode(mode_w), .last_b(last_b_w),
        .upper(upper_w), .cancel(cancel_w)
    );

    pb_ext_latch #(
        .DATA_W(DATA_W), .HI_W(HI_W), .LO_W(LO_W)
    ) u_ovr (
        .clk(clk), .rst_n(rst_n),
        .ext_attr_en(ext_attr_en), .nt_fetch(nt_fetch), .nt_byte(nt_byte),
        .upper(upper_w), .cancel(cancel_w),
        .ovr_valid(ovr_valid_w), .ovr_bank(ovr_bank_w)
    );

    pb_addr_mux #(
        .DATA_W(DATA_W), .HI_W(HI_W),
        .BANKS_A(BANKS_A), .BANKS_B(BANKS_B), .OVR_W(OVR_W)
    ) u_mux (
        .banks(banks_w), .mode(mode_w), .last_b(last_b_w),
        .tall_spr(tall_spr), .fetch_bg(fetch_bg),
        .ext_attr_en(ext_attr_en), .ovr_valid(ovr_valid_w), .ovr_bank(ovr_bank_w),
        .pat_addr(pat_addr), .rom_addr(rom_addr)
    );

    // R8
    tall_spr_set_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tall_spr && !fetch_bg && mode_w == PG_1K)
        |-> rom_addr[BANK_W+9:10] == banks_w[pat_addr[12:10]]);

    // R3
    page1k_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == PG_1K) |-> rom_addr[9:0] == pat_addr[9:0]);

    // R9
    ovr_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_attr_en && fetch_bg && ovr_valid_w)
        |-> rom_addr[OVR_W+11:12] == ovr_bank_w);
endmodule

// File: tb/tb_pat_bank_addr_gen.sv
module tb_pat_bank_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        ext_attr_en = 1'b0;
    logic        nt_fetch = 1'b0;
    logic [7:0]  nt_byte = '0;
    logic [12:0] pat_addr = '0;
    logic        fetch_bg = 1'b0;
    logic        tall_spr = 1'b0;
    logic [20:0] rom_addr;

    int total = 0;
    int bad = 0;

    logic [9:0] bank_m [12];
    logic [1:0] mode_m = 2'd3;
    bit         last_b_m = 1'b0;
    logic [1:0] upper_m = 2'd0;
    bit         ov_m = 1'b0;
    logic [7:0] ov_bank_m = '0;

    always #5 clk = ~clk;

    pat_bank_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ext_attr_en(ext_attr_en), .nt_fetch(nt_fetch), .nt_byte(nt_byte),
        .pat_addr(pat_addr), .fetch_bg(fetch_bg), .tall_spr(tall_spr), .rom_addr(rom_addr)
    );

    function automatic logic [20:0] exp_rom(input logic [12:0] a, input bit tall, input bit bg);
        bit useb;
        int idx;
        useb = tall ? bg : last_b_m;
        if (ext_attr_en && bg && ov_m) return 21'({ov_bank_m, a[11:0]});
        case (mode_m)
            2'd0: if (useb) return 21'({bank_m[11][7:0], a[11:0]});
                  else      return {bank_m[7][7:0], a[12:0]};
            2'd1: begin
                idx = useb ? 11 : (a[12] ? 7 : 3);
                return 21'({bank_m[idx][7:0], a[11:0]});
            end
            2'd2: begin
                idx = useb ? (a[11] ? 11 : 9) : (int'(a[12:11]) * 2 + 1);
                return {bank_m[idx], a[10:0]};
            end
            default: begin
                idx = useb ? 8 + int'(a[11:10]) : int'(a[12:10]);
                return 21'({bank_m[idx], a[9:0]});
            end
        endcase
    endfunction

    task automatic check(input string tag, input logic [20:0] exp);
        total++;
        if (rom_addr !== exp) begin
            bad++;
            $display("FAIL %s pat=%h tall=%0b bg=%0b got=%h exp=%h",
                     tag, pat_addr, tall_spr, fetch_bg, rom_addr, exp);
        end
    endtask

    task automatic probe(input string tag, input logic [12:0] a, input bit tall, input bit bg);
        pat_addr = a;
        tall_spr = tall;
        fetch_bg = bg;
        #1;
        check(tag, exp_rom(a, tall, bg));
    endtask

    task automatic wr(input logic [15:0] ad, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = ad;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (ad == 16'h5101) begin mode_m = d[1:0]; ov_m = 0; end
        if (ad == 16'h5130) begin upper_m = d[1:0]; ov_m = 0; end
        if (ad >= 16'h5120 && ad <= 16'h512B) begin
            bank_m[ad - 16'h5120] = {upper_m, d};
            last_b_m = (ad >= 16'h5128);
            ov_m = 0;
        end
    endtask

    task automatic ntf(input logic [7:0] b);
        @(negedge clk);
        nt_fetch = 1'b1;
        nt_byte = b;
        @(negedge clk);
        nt_fetch = 1'b0;
        if (ext_attr_en) begin ov_m = 1; ov_bank_m = {upper_m, b[5:0]}; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 12; i++) bank_m[i] = 10'h3FF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        probe("R1", 13'h0000, 0, 0);
        probe("R1", 13'h1ABC, 0, 1);
        total++;
        if (rom_addr !== {1'b0, 10'h3FF, 10'h2BC}) begin
            bad++;
            $display("FAIL R1 got=%h exp=%h", rom_addr, {1'b0, 10'h3FF, 10'h2BC});
        end

        // R2: fill all twelve registers with distinct values and upper bits
        for (int i = 0; i < 12; i++) begin
            wr(16'h5130, 8'(i % 4));
            wr(16'h5120 + 16'(i), 8'(8'h1D * (i + 1) + 8'h40));
        end
        wr(16'h5101, 8'd3);
        wr(16'h5130, 8'd2);
        wr(16'h5125, 8'h3C);
        pat_addr = 13'h1400; tall_spr = 0; fetch_bg = 0; #1;
        total++;
        if (rom_addr[19:10] !== 10'h23C) begin
            bad++;
            $display("FAIL R2 got=%h exp=%h", rom_addr[19:10], 10'h23C);
        end

        // R3..R8: sweep every mode, last set, tall flag, phase and page
        for (int m = 0; m < 4; m++) begin
            wr(16'h5101, 8'(m));
            for (int s = 0; s < 2; s++) begin
                if (s == 0) wr(16'h5122, 8'h5A); else wr(16'h512A, 8'hA5);
                for (int t = 0; t < 2; t++) begin
                    for (int g = 0; g < 2; g++) begin
                        for (int p = 0; p < 8; p++) begin
                            for (int o = 0; o < 3; o++) begin
                                logic [12:0] a;
                                string tag;
                                bit ub;
                                a = 13'(p * 1024 + (o == 0 ? 0 : (o == 1 ? 'h3FF : 'h155)));
                                ub = t ? g : last_b_m;
                                if (t) tag = "R8";
                                else if (ub && a[12]) tag = "R7";
                                else if (m == 3) tag = "R3";
                                else if (m == 2) tag = "R4";
                                else if (m == 1) tag = "R5";
                                else tag = "R6";
                                probe(tag, a, t[0], g[0]);
                            end
                        end
                    end
                end
            end
        end

        // R9: extended-attribute override
        wr(16'h5101, 8'd3);
        wr(16'h5130, 8'd1);
        ntf(8'hC7);                       // ext off: latches nothing
        probe("R9", 13'h1ABC, 0, 1);
        ext_attr_en = 1'b1;
        ntf(8'hC7);                       // bank = {01, 000111} = 0x47
        probe("R9", 13'h1ABC, 0, 1);
        total++;
        if (rom_addr !== 21'h47ABC) begin
            bad++;
            $display("FAIL R9 got=%h exp=%h", rom_addr, 21'h47ABC);
        end
        probe("R9", 13'h0123, 0, 0);      // sprite fetch: normal
        probe("R9", 13'h0123, 1, 1);      // tall bg still overridden
        ext_attr_en = 1'b0;
        probe("R9", 13'h0123, 0, 1);      // ext off: normal
        ext_attr_en = 1'b1;

        // R10: cancellation
        wr(16'h5105, 8'hFF);              // unrelated address keeps override
        probe("R10", 13'h0FFF, 0, 1);
        wr(16'h5101, 8'd3);
        probe("R10", 13'h0FFF, 0, 1);
        ntf(8'h3F);
        probe("R10", 13'h0FFF, 0, 1);
        wr(16'h5129, 8'h77);
        probe("R10", 13'h0FFF, 0, 1);
        ntf(8'h15);
        probe("R10", 13'h0FFF, 0, 1);
        wr(16'h5130, 8'd3);
        probe("R10", 13'h0FFF, 0, 1);
        // write and nametable fetch in the same cycle: write wins
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 16'h5101; wr_data = 8'd3;
        nt_fetch = 1'b1; nt_byte = 8'h2A;
        @(negedge clk);
        wr_en = 1'b0; nt_fetch = 1'b0;
        ov_m = 0;
        probe("R10", 13'h0FFF, 0, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule